// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for one read or write burst of a synchronous DRAM controller. A start pulse carries a starting column and a read/write flag. From the next clock, the block emits one column address per cycle and flags the final beat. The burst length, the beat ordering and the write mode come from a small mode register that is loaded with a strobe.

Two orderings are supported. Sequential order counts the low column bits upward and wraps them within an aligned block. Interleaved order XORs the beat index into the low bits. A full-page setting walks every column of the row and wraps until a stop arrives. A write-mode bit makes writes single-beat while reads keep the programmed length. A burst ends early on a stop. A new start on any cycle replaces the burst in progress.

Top module: `burst_col_gen`

## Requirements
- R1: After reset no beat is issued (`valid_o`=0, `last_o`=0). The mode register holds length code 000 (one beat), sequential order and burst writes.
- R2: A cycle with `start_i`=1 makes `valid_o`=1 from the following cycle, with `col_o` equal to the start column. Further beats follow one per clock.
- R3: Length codes 000, 001, 010 and 011 on `mode_bl_i` give bursts of 1, 2, 4 and 8 beats. `last_o` is 1 only on the final beat, and `valid_o` is 0 in the cycle after it unless a new start arrives.
- R4: With `mode_il_i`=0, beat i carries the low log2(length) column bits equal to (start low bits + i) modulo the length. All higher column bits equal the start column.
- R5: With `mode_il_i`=1, beat i carries the start column XOR i.
- R6: Code 111 with sequential order is full page. The column counts up from the start modulo 2^COL_W, `last_o` stays 0, and beats continue until a stop or a new start.
- R7: A mode load whose length code is 100, 101 or 110, or is 111 with `mode_il_i`=1, is ignored as a whole. Length, order and write mode all keep their previous values.
- R8: With `mode_single_wr_i`=1 loaded, a burst started with `wr_i`=1 has exactly one beat, and a read burst still has the programmed length. `wr_o` carries the `wr_i` value of the start.
- R9: `stop_i`=1 during a beat, without a start, makes `valid_o` 0 in the next cycle.
- R10: A start during a running burst replaces it. The next cycle shows beat 0 of the new burst at the new column.
- R11: A mode load during a burst does not change that burst's length or order. The new mode applies from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_ld_i | input | 1 | Load the mode fields into the mode register |
| mode_bl_i | input | 3 | Burst length code |
| mode_il_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| mode_single_wr_i | input | 1 | 1: writes are single-beat, reads burst |
| start_i | input | 1 | Begin a new burst |
| wr_i | input | 1 | 1: write burst, 0: read burst |
| col_i | input | COL_W | Starting column |
| stop_i | input | 1 | End the current burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is present |
| last_o | output | 1 | Current beat is the final one |
| wr_o | output | 1 | Direction of the current burst |

## Verification
The hardest case to reach is the full-page wrap, which needs more than 2^COL_W consecutive beats with no stop. The stimulus starts a full-page burst two columns below the top of the row. It follows the burst for over 512 beats, so the wrap to column 0 and the return past the start column are both seen before the stop is applied. Mode loads during a live burst and restarts in mid-burst are also driven on chosen beats. This shows that the latched burst settings and the replacement path behave as required.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  typedef struct packed {
    logic [2:0] bl;
    logic       il;
    logic       single_wr;
  } bcg_mode_t;

  function automatic logic bl_legal(logic [2:0] code, logic il);
    case (code)
      3'b000, 3'b001, 3'b010, 3'b011: return 1'b1;
      3'b111:                         return !il;
      default:                        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
  import bcg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ld_i,
  input  bcg_mode_t mode_i,
  output bcg_mode_t mode_o
);

  bcg_mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           mode_q <= '0;
    else if (ld_i && bl_legal(mode_i.bl, mode_i.il)) mode_q <= mode_i;
  end

  assign mode_o = mode_q;

  assert_reserved_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !bl_legal(mode_i.bl, mode_i.il)) |=> $stable(mode_q));

  assert_legal_taken_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && bl_legal(mode_i.bl, mode_i.il)) |=> (mode_q == $past(mode_i)));

endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
  parameter int COL_W = 9,
  parameter int LGW   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [LGW-1:0]   lg_i,
  input  logic             full_i,
  input  logic             il_i,
  input  logic             wr_i,
  output logic             valid_o,
  output logic             last_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] base_o,
  output logic [LGW-1:0]   lg_o,
  output logic             il_o,
  output logic             wr_o
);

  logic             valid_q, full_q, il_q, wr_q;
  logic [COL_W-1:0] idx_q, base_q, len_m1;
  logic [LGW-1:0]   lg_q;
  logic             last;

  assign len_m1 = (COL_W'(1) << lg_q) - COL_W'(1);
  assign last   = valid_q && !full_q && (idx_q == len_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      base_q  <= '0;
      lg_q    <= '0;
      full_q  <= 1'b0;
      il_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      idx_q   <= '0;
      base_q  <= base_i;
      lg_q    <= lg_i;
      full_q  <= full_i;
      il_q    <= il_i;
      wr_q    <= wr_i;
    end else if (valid_q) begin
      if (stop_i || last) valid_q <= 1'b0;
      else                idx_q   <= idx_q + COL_W'(1);
    end
  end

  assign valid_o = valid_q;
  assign last_o  = last;
  assign idx_o   = idx_q;
  assign base_o  = base_q;
  assign lg_o    = lg_q;
  assign il_o    = il_q;
  assign wr_o    = wr_q;

  assert_start_beat0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_q && idx_q == '0 && base_q == $past(base_i)));

  assert_end_after_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !start_i) |=> !valid_q);

  assert_stop_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && stop_i && !start_i) |=> !valid_q);

  assert_full_runs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && full_q && !stop_i && !start_i) |=> (valid_q && idx_q == $past(idx_q) + COL_W'(1)));

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
  parameter int COL_W = 9,
  parameter int LGW   = 4
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [LGW-1:0]   lg_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] mask, seq_col, il_col;

  // lg == COL_W shifts out to zero, so the mask covers the whole row
  assign mask    = (COL_W'(1) << lg_i) - COL_W'(1);
  assign seq_col = (base_i & ~mask) | ((base_i + idx_i) & mask);
  assign il_col  = base_i ^ (idx_i & mask);
  assign col_o   = il_i ? il_col : seq_col;

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_ld_i,
  input  logic [2:0]       mode_bl_i,
  input  logic             mode_il_i,
  input  logic             mode_single_wr_i,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             wr_o
);

  localparam int LGW = $clog2(COL_W + 1);
  localparam logic [LGW-1:0] LG_FULL = LGW'(COL_W);

  bcg_mode_t        mode_in, mode;
  logic [LGW-1:0]   st_lg, cur_lg;
  logic             st_full, cur_il, one_beat;
  logic [COL_W-1:0] cur_idx, cur_base;

  assign mode_in = '{bl: mode_bl_i, il: mode_il_i, single_wr: mode_single_wr_i};

  bcg_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (mode_ld_i),
    .mode_i (mode_in),
    .mode_o (mode)
  );

  assign one_beat = wr_i && mode.single_wr;

  always_comb begin
    st_full = 1'b0;
    case (mode.bl)
      3'b000:  st_lg = LGW'(0);
      3'b001:  st_lg = LGW'(1);
      3'b010:  st_lg = LGW'(2);
      3'b011:  st_lg = LGW'(3);
      default: begin st_lg = LG_FULL; st_full = 1'b1; end
    endcase
    if (one_beat) begin
      st_lg   = LGW'(0);
      st_full = 1'b0;
    end
  end

  bcg_beat_ctr #(.COL_W(COL_W), .LGW(LGW)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .base_i  (col_i),
    .lg_i    (st_lg),
    .full_i  (st_full),
    .il_i    (mode.il),
    .wr_i    (wr_i),
    .valid_o (valid_o),
    .last_o  (last_o),
    .idx_o   (cur_idx),
    .base_o  (cur_base),
    .lg_o    (cur_lg),
    .il_o    (cur_il),
    .wr_o    (wr_o)
  );

  bcg_addr_map #(.COL_W(COL_W), .LGW(LGW)) u_map (
    .base_i (cur_base),
    .idx_i  (cur_idx),
    .lg_i   (cur_lg),
    .il_i   (cur_il),
    .col_o  (col_o)
  );

  assert_single_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && wr_i && mode.single_wr) |=> (valid_o && last_o && wr_o));

  assert_first_col_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (col_o == $past(col_i)));

endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  localparam int CLK_P = 10;
  localparam int COL_W = 9;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic             mode_ld = 0, mode_il = 0, mode_sw = 0;
  logic [2:0]       mode_bl = 0;
  logic             start = 0, wr = 0, stop = 0;
  logic [COL_W-1:0] col = 0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, wr_o;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
    .clk_i(clk), .rst_ni(rst_n), .mode_ld_i(mode_ld), .mode_bl_i(mode_bl),
    .mode_il_i(mode_il), .mode_single_wr_i(mode_sw), .start_i(start), .wr_i(wr),
    .col_i(col), .stop_i(stop), .col_o(col_o), .valid_o(valid_o),
    .last_o(last_o), .wr_o(wr_o));

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int i, int len, bit il);
    int lo;
    if (il) return s ^ i;
    lo = s % len;
    return s - lo + ((lo + i) % len);
  endfunction

  task automatic load_mode(logic [2:0] bl, logic il, logic sw);
    @(negedge clk);
    mode_bl = bl; mode_il = il; mode_sw = sw; mode_ld = 1;
    @(negedge clk);
    mode_ld = 0;
  endtask

  // checks beats from..to-1; beat "from" is already on the outputs at entry
  task automatic follow(string req, int s, int len, bit il, bit full, bit w,
                        int from, int to, bit expect_end);
    for (int i = from; i < to; i++) begin
      if (i != from) @(negedge clk);
      chk(req, valid_o, 1);
      chk(req, col_o, exp_col(s, i, full ? (1 << COL_W) : len, il));
      chk(req, last_o, (!full && i == len - 1) ? 1 : 0);
      chk(req, wr_o, w);
    end
    if (expect_end) begin
      @(negedge clk);
      chk(req, valid_o, 0);
    end
  endtask

  task automatic begin_burst(int s, bit w);
    @(negedge clk);
    col = COL_W'(s); wr = w; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic t_reset;
    chk("R1 valid", valid_o, 0);
    chk("R1 last", last_o, 0);
    begin_burst(9'h0A3, 1);
    follow("R1 default", 9'h0A3, 1, 0, 0, 1, 0, 1, 1);
  endtask

  task automatic t_seq;
    load_mode(3'b001, 0, 0); begin_burst(9'h0D5, 0); follow("R3 R4 bl2", 9'h0D5, 2, 0, 0, 0, 0, 2, 1);
    load_mode(3'b010, 0, 0); begin_burst(9'h0D6, 0); follow("R3 R4 bl4", 9'h0D6, 4, 0, 0, 0, 0, 4, 1);
    load_mode(3'b011, 0, 0); begin_burst(9'h13D, 1); follow("R3 R4 bl8", 9'h13D, 8, 0, 0, 1, 0, 8, 1);
  endtask

  task automatic t_il;
    load_mode(3'b011, 1, 0); begin_burst(9'h1A5, 0); follow("R5 il8", 9'h1A5, 8, 1, 0, 0, 0, 8, 1);
    load_mode(3'b010, 1, 0); begin_burst(9'h00B, 0); follow("R5 il4", 9'h00B, 4, 1, 0, 0, 0, 4, 1);
  endtask

  task automatic t_full;
    load_mode(3'b111, 0, 0);
    begin_burst(9'h1FE, 0);
    follow("R6 full", 9'h1FE, 0, 0, 1, 0, 0, 520, 0);
    stop = 1;
    @(negedge clk);
    stop = 0;
    chk("R9 stop full", valid_o, 0);
  endtask

  task automatic t_reserved;
    load_mode(3'b010, 0, 0);
    load_mode(3'b101, 1, 1);
    begin_burst(9'h031, 1); follow("R7 code101", 9'h031, 4, 0, 0, 1, 0, 4, 1);
    load_mode(3'b111, 1, 1);
    begin_burst(9'h032, 1); follow("R7 il111", 9'h032, 4, 0, 0, 1, 0, 4, 1);
  endtask

  task automatic t_single_wr;
    load_mode(3'b011, 0, 1);
    begin_burst(9'h044, 1); follow("R8 write", 9'h044, 1, 0, 0, 1, 0, 1, 1);
    begin_burst(9'h044, 0); follow("R8 read", 9'h044, 8, 0, 0, 0, 0, 8, 1);
    load_mode(3'b111, 0, 1);
    begin_burst(9'h100, 1); follow("R8 full write", 9'h100, 1, 0, 0, 1, 0, 1, 1);
  endtask

  task automatic t_stop;
    load_mode(3'b011, 0, 0);
    begin_burst(9'h0F2, 0);
    follow("R9 pre", 9'h0F2, 8, 0, 0, 0, 0, 3, 0);
    stop = 1;
    @(negedge clk);
    stop = 0;
    chk("R9 stop", valid_o, 0);
  endtask

  task automatic t_replace;
    load_mode(3'b011, 0, 0);
    begin_burst(9'h010, 0);
    follow("R10 first", 9'h010, 8, 0, 0, 0, 0, 3, 0);
    col = 9'h123; wr = 1; start = 1;
    @(negedge clk);
    start = 0;
    follow("R10 second", 9'h123, 8, 0, 0, 1, 0, 8, 1);
  endtask

  task automatic t_mid_mode;
    load_mode(3'b011, 0, 0);
    begin_burst(9'h077, 0);
    follow("R11 pre", 9'h077, 8, 0, 0, 0, 0, 2, 0);
    mode_bl = 3'b001; mode_il = 1; mode_sw = 0; mode_ld = 1;
    @(negedge clk);
    mode_ld = 0;
    follow("R11 kept", 9'h077, 8, 0, 0, 0, 2, 8, 1);
    begin_burst(9'h077, 0); follow("R11 new", 9'h077, 2, 1, 0, 0, 0, 2, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_il();
    t_full();
    t_reserved();
    t_single_wr();
    t_stop();
    t_replace();
    t_mid_mode();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule